// File: doc/BRIEF.md
# Matrix Keypad Scanner

The block sweeps a key matrix of up to 16 rows and 8 columns from a slow clock. It pulls one row low at a time, reads the column sense lines through a two-flop synchronizer, and accepts a key only once it has been seen pressed long enough. Each full sweep produces a snapshot of up to eight pressed keys. Software reads that snapshot as packed one-byte entries.

Software works through a word-addressed register port, with reads returned combinationally. The registers hold a control word, a status word and a per-row wake mask. Status carries the number of held keys and two sticky flags: one for a count threshold and one for a keypress. Each flag is cleared by writing a one to it. A single interrupt line combines the two flags according to their enables.

Top module: `keypad_scanner`

## Requirements
- R1: A pressed key at row r, column c is stored as the byte {1, r[3:0], c[2:0]}, so its scan code is r*8+c. Keys are stored in sweep order: ascending row, then ascending column. Entry k is placed in byte k%4 of entry word k/4. Entry word 0 is at register 2 and entry word 1 at register 3. Bytes beyond the count read as zero.
- R2: `rowDrive_n` drives at most one row low at a time. All rows stay high while the block is disabled, during the start delay and during the commit cycle.
- R3: Each sweep consists of one commit cycle, then 5 delay cycles, then each row in turn held low for 16+D cycles. D is the debounce field.
- R4: Status bits 7:4 (register 1) hold the number of entries committed by the last sweep. This number is at most 8. Keys found after the eighth in a sweep are dropped.
- R5: Reading entry word 1 empties the snapshot, and the count reads 0 until the next commit. Reading entry word 0 changes nothing.
- R6: A key is accepted only if its column was sensed low in each of the last D+1 cycles of its row window.
- R7: At each commit, status bit 2 is set if the committed count is non-zero and at least the threshold field.
- R8: At each commit, status bit 0 is set if an accepted key lies in a row whose mask is not all ones. Masks are at registers 16+row, and a row mask of all ones blocks that row.
- R9: Writing 1 to a status bit clears it. A set event in the same cycle wins over the clear.
- R10: With the enable bit (control bit 0, register 0) clear, the scan state, snapshot, count and flags are held at zero.
- R11: `irq` is the OR of (bit 0 AND control bit 1) and (bit 2 AND control bit 3). The debounce field is control bits 13:4 and the threshold field is control bits 17:14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| colSense_n | input | 8 | Column sense lines, low when a key in the driven row is pressed |
| rowDrive_n | output | 16 | Row drive lines, active low |
| regAddr | input | 6 | Word address of the register access |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (triggers the pop on entry word 1) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the current address |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong sweep counter shows up on `rowDrive_n` within one row window, as a row held for the wrong number of cycles or two rows low together. A bad collector index or commit shows at the next commit, one sweep later, as misordered bytes in the entry words or a wrong count in status. Flag and mask faults surface at that same commit through status bits 0 and 2 and `irq`. Pop and enable faults show on the very next read of status.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int ROW_IDX_W = 4;
  localparam int ENTRY_W   = 8;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_ENTRY  = 2;
  localparam int ADDR_MASK   = 16;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_KPIE_BIT = 1;
  localparam int CTRL_FIE_BIT = 3;
  localparam int CTRL_DB_LSB  = 4;
  localparam int CTRL_THR_LSB = 14;
  localparam int THR_W        = 4;

  localparam int STAT_KP_BIT   = 0;
  localparam int STAT_FIFO_BIT = 2;
  localparam int STAT_CNT_LSB  = 4;

  typedef struct packed {
    logic                 rowActive;
    logic                 rowFirst;
    logic                 rowLast;
    logic                 scanEnd;
    logic [ROW_IDX_W-1:0] rowIdx;
  } scanStrobe_t;
endpackage

// File: rtl/kps_ctrl.sv
module kps_ctrl
  import kps_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int START_DLY = 5,
  parameter int ROW_BASE  = 16,
  parameter int DB_W      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [DB_W-1:0] dbCount,
  output scanStrobe_t     strobe,
  output logic [ROWS-1:0] rowDrive_n
);
  localparam int CNT_W = DB_W + 2;

  typedef enum logic [1:0] {S_OFF, S_DELAY, S_ROW, S_END} scanState_t;

  scanState_t           state;
  logic [CNT_W-1:0]     cnt;
  logic [ROW_IDX_W-1:0] row;
  logic [CNT_W-1:0]     rowLen;
  logic                 cntDone;

  assign rowLen  = CNT_W'(ROW_BASE) + CNT_W'(dbCount);
  assign cntDone = (state == S_ROW) ? (cnt == rowLen - 1'b1)
                                    : (cnt == CNT_W'(START_DLY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
      row   <= '0;
    end else if (!enable) begin
      state <= S_OFF;
      cnt   <= '0;
      row   <= '0;
    end else begin
      case (state)
        S_OFF: begin
          state <= S_DELAY;
          cnt   <= '0;
        end
        S_DELAY: begin
          if (cntDone) begin
            state <= S_ROW;
            cnt   <= '0;
            row   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ROW: begin
          if (cntDone) begin
            cnt <= '0;
            if (row == ROW_IDX_W'(ROWS - 1)) state <= S_END;
            else row <= row + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= S_DELAY;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.rowActive = (state == S_ROW);
    strobe.rowFirst  = (state == S_ROW) && (cnt == '0);
    strobe.rowLast   = (state == S_ROW) && cntDone;
    strobe.scanEnd   = (state == S_END);
    strobe.rowIdx    = row;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_drive
    assign rowDrive_n[r] = !((state == S_ROW) && (row == ROW_IDX_W'(r)));
  end
endmodule

// File: rtl/kps_datapath.sv
module kps_datapath
  import kps_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 8,
  parameter int DEPTH  = 8,
  parameter int DB_W   = 10,
  parameter int ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  scanStrobe_t                   strobe,
  input  logic [COLS-1:0]               colSense_n,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWr,
  input  logic                          regRd,
  input  logic [31:0]                   regWdata,
  output logic [31:0]                   regRdata,
  output logic                          enable,
  output logic [DB_W-1:0]               dbCount,
  output logic [$clog2(DEPTH+1)-1:0]    fifoCount,
  output logic                          kpFlag,
  output logic                          fifoFlag,
  output logic                          irq
);
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int NUM_WORDS = DEPTH / 4;
  localparam int POP_ADDR  = ADDR_ENTRY + NUM_WORDS - 1;
  localparam logic [DB_W-1:0] RUN_MAX = '1;

  logic                    kpIe, fifoIe;
  logic [THR_W-1:0]        thresh;
  logic [COLS-1:0]         rowMask [ROWS];
  logic [COLS-1:0]         colS1, colS2, colLow, pressed;
  logic [DB_W-1:0]         runCnt [COLS];
  logic [ENTRY_W-1:0]      coll [DEPTH];
  logic [ENTRY_W-1:0]      collNext [DEPTH];
  logic [CNT_W-1:0]        collCount, collCountNext;
  logic                    wakeHit, wakeNext;
  logic [ENTRY_W-1:0]      fifo [DEPTH];
  logic                    pop, statWr, setKp, setFifo;

  assign pop    = regRd && (regAddr == ADDR_W'(POP_ADDR));
  assign statWr = regWr && (regAddr == ADDR_W'(ADDR_STATUS));

  // control register and row masks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      kpIe    <= 1'b0;
      fifoIe  <= 1'b0;
      dbCount <= '0;
      thresh  <= '0;
      for (int r = 0; r < ROWS; r++) rowMask[r] <= '0;
    end else if (regWr) begin
      if (regAddr == ADDR_W'(ADDR_CTRL)) begin
        enable  <= regWdata[CTRL_EN_BIT];
        kpIe    <= regWdata[CTRL_KPIE_BIT];
        fifoIe  <= regWdata[CTRL_FIE_BIT];
        dbCount <= regWdata[CTRL_DB_LSB +: DB_W];
        thresh  <= regWdata[CTRL_THR_LSB +: THR_W];
      end
      for (int r = 0; r < ROWS; r++)
        if (regAddr == ADDR_W'(ADDR_MASK + r)) rowMask[r] <= regWdata[COLS-1:0];
    end
  end

  // column synchronizer and per-column run counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colS1 <= '1;
      colS2 <= '1;
    end else begin
      colS1 <= colSense_n;
      colS2 <= colS1;
    end
  end

  assign colLow = ~colS2;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) runCnt[c] <= '0;
      else if (!enable) runCnt[c] <= '0;
      else if (strobe.rowActive) begin
        if (strobe.rowFirst || !colLow[c]) runCnt[c] <= '0;
        else if (runCnt[c] != RUN_MAX) runCnt[c] <= runCnt[c] + 1'b1;
      end
    end
    assign pressed[c] = strobe.rowLast && colLow[c] && (runCnt[c] >= dbCount);
  end

  // collector: append this row's accepted keys in column order
  always_comb begin
    collCountNext = collCount;
    wakeNext      = wakeHit;
    for (int i = 0; i < DEPTH; i++) collNext[i] = coll[i];
    for (int c = 0; c < COLS; c++) begin
      if (pressed[c]) begin
        if (collCountNext < CNT_W'(DEPTH)) begin
          collNext[collCountNext[IDX_W-1:0]] = {1'b1, strobe.rowIdx, 3'(c)};
          collCountNext = collCountNext + 1'b1;
        end
        if (rowMask[strobe.rowIdx] != '1) wakeNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collCount <= '0;
      wakeHit   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) coll[i] <= '0;
    end else if (!enable || strobe.scanEnd) begin
      collCount <= '0;
      wakeHit   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) coll[i] <= '0;
    end else if (strobe.rowLast) begin
      collCount <= collCountNext;
      wakeHit   <= wakeNext;
      for (int i = 0; i < DEPTH; i++) coll[i] <= collNext[i];
    end
  end

  // snapshot presented to software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifoCount <= '0;
      for (int i = 0; i < DEPTH; i++) fifo[i] <= '0;
    end else if (!enable) begin
      fifoCount <= '0;
      for (int i = 0; i < DEPTH; i++) fifo[i] <= '0;
    end else if (strobe.scanEnd) begin
      fifoCount <= collCount;
      for (int i = 0; i < DEPTH; i++) fifo[i] <= coll[i];
    end else if (pop) begin
      fifoCount <= '0;
      for (int i = 0; i < DEPTH; i++) fifo[i] <= '0;
    end
  end

  // sticky status flags, write one to clear, set wins
  assign setKp   = strobe.scanEnd && wakeHit;
  assign setFifo = strobe.scanEnd && (collCount != '0) &&
                   (CNT_W'(collCount) >= CNT_W'(thresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kpFlag   <= 1'b0;
      fifoFlag <= 1'b0;
    end else if (!enable) begin
      kpFlag   <= 1'b0;
      fifoFlag <= 1'b0;
    end else begin
      kpFlag   <= (kpFlag   && !(statWr && regWdata[STAT_KP_BIT]))   || setKp;
      fifoFlag <= (fifoFlag && !(statWr && regWdata[STAT_FIFO_BIT])) || setFifo;
    end
  end

  assign irq = (kpFlag && kpIe) || (fifoFlag && fifoIe);

  // read mux
  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      regRdata[CTRL_EN_BIT]               = enable;
      regRdata[CTRL_KPIE_BIT]             = kpIe;
      regRdata[CTRL_FIE_BIT]              = fifoIe;
      regRdata[CTRL_DB_LSB +: DB_W]       = dbCount;
      regRdata[CTRL_THR_LSB +: THR_W]     = thresh;
    end
    if (regAddr == ADDR_W'(ADDR_STATUS)) begin
      regRdata[STAT_KP_BIT]               = kpFlag;
      regRdata[STAT_FIFO_BIT]             = fifoFlag;
      regRdata[STAT_CNT_LSB +: CNT_W]     = fifoCount;
    end
    for (int w = 0; w < NUM_WORDS; w++)
      if (regAddr == ADDR_W'(ADDR_ENTRY + w))
        for (int b = 0; b < 4; b++) regRdata[8*b +: 8] = fifo[4*w + b];
    for (int r = 0; r < ROWS; r++)
      if (regAddr == ADDR_W'(ADDR_MASK + r)) regRdata[COLS-1:0] = rowMask[r];
  end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kps_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int COLS      = 8,
  parameter int DEPTH     = 8,
  parameter int DB_W      = 10,
  parameter int ADDR_W    = 6,
  parameter int START_DLY = 5,
  parameter int ROW_BASE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS-1:0]   colSense_n,
  output logic [ROWS-1:0]   rowDrive_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  scanStrobe_t      strobe;
  logic             enable;
  logic [DB_W-1:0]  dbCount;
  logic [CNT_W-1:0] fifoCount;
  logic             kpFlag, fifoFlag;

  kps_ctrl #(
    .ROWS(ROWS), .START_DLY(START_DLY), .ROW_BASE(ROW_BASE), .DB_W(DB_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dbCount(dbCount),
    .strobe(strobe), .rowDrive_n(rowDrive_n)
  );

  kps_datapath #(
    .ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH), .DB_W(DB_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .colSense_n(colSense_n),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .enable(enable), .dbCount(dbCount),
    .fifoCount(fifoCount), .kpFlag(kpFlag), .fifoFlag(fifoFlag), .irq(irq)
  );
endmodule

// File: rtl/kps_checker.sv
module kps_checker
  import kps_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ROWS-1:0]   rowDrive_n,
  input logic              irq,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRd,
  input logic              enable,
  input scanStrobe_t       strobe,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              kpFlag,
  input logic              fifoFlag
);
  localparam int POP_ADDR = ADDR_ENTRY + DEPTH / 4 - 1;

  p_rows_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~rowDrive_n));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount <= CNT_W'(DEPTH));

  p_pop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (regRd && regAddr == ADDR_W'(POP_ADDR) && enable && !strobe.scanEnd)
      |=> (fifoCount == '0));

  p_disabled_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (fifoCount == '0 && !kpFlag && !fifoFlag && rowDrive_n == '1));

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (kpFlag || fifoFlag));
endmodule

bind keypad_scanner kps_checker #(
  .ROWS(ROWS), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W($clog2(DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .rowDrive_n(rowDrive_n), .irq(irq),
  .regAddr(regAddr), .regRd(regRd), .enable(enable), .strobe(strobe),
  .fifoCount(fifoCount), .kpFlag(kpFlag), .fifoFlag(fifoFlag)
);

// File: tb/keypad_scanner_test.sv
`timescale 1ns/1ps
module keypad_scanner_test;
  localparam int ROWS = 16;
  localparam int COLS = 8;

  typedef struct packed {
    logic [2:0][7:0] keys;
    logic [31:0]     word0;
    logic [3:0]      cnt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'h000080, 32'h00000080, 4'd1},
    '{24'h0000FF, 32'h000000FF, 4'd1},
    '{24'h009195, 32'h00009591, 4'd2},
    '{24'h8ECBA0, 32'h00CBA08E, 4'd3},
    '{24'h000000, 32'h00000000, 4'd0},
    '{24'h00BA8A, 32'h0000BA8A, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [COLS-1:0] colSense_n;
  logic [ROWS-1:0] rowDrive_n;
  logic [5:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq;
  logic [ROWS-1:0][COLS-1:0] keys = '0;
  logic flickOn = 1'b0, flickPhase = 1'b0;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  keypad_scanner uut (
    .clk(clk), .rst_n(rst_n), .colSense_n(colSense_n), .rowDrive_n(rowDrive_n),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  always @(negedge clk) flickPhase <= ~flickPhase;

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      colSense_n[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (!rowDrive_n[r] && (keys[r][c] || (flickOn && flickPhase && r == 3 && c == 2)))
          colSense_n[c] = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = 6'(addr); regWdata = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input int addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = 6'(addr); regRd = 1'b1;
    #1 data = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  function automatic logic [31:0] ctrlWord(input bit kpIe, input bit fIe,
                                           input int db, input int thr);
    return 32'h1 | (32'(kpIe) << 1) | (32'(fIe) << 3) | (32'(db) << 4) | (32'(thr) << 14);
  endfunction

  task automatic syncToScan();
    @(negedge rowDrive_n[0]);
    @(negedge clk);
  endtask

  task automatic settle();
    syncToScan();
    syncToScan();
  endtask

  task automatic setKeys(input logic [2:0][7:0] kb);
    keys = '0;
    for (int k = 0; k < 3; k++)
      if (kb[k][7]) keys[kb[k][6:3]][kb[k][2:0]] = 1'b1;
  endtask

  task automatic measureRow(input string tag, input int expLen);
    int len;
    syncToScan();
    len = 0;
    while (rowDrive_n[0] == 1'b0) begin
      len++;
      @(negedge clk);
    end
    check(tag, len, expLen);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd2;
    int gap;
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R2 R10
    check("R2 reset rows high", rowDrive_n, 32'h0000FFFF);
    check("R10 reset irq", irq, 0);
    regRead(1, rd);
    check("R10 reset status", rd, 0);

    // R3 sweep timing with D=0
    regWrite(0, ctrlWord(0, 0, 0, 1));
    measureRow("R3 row dwell D=0", 16);
    @(posedge rowDrive_n[ROWS-1]);
    @(negedge clk);
    gap = 0;
    while (rowDrive_n == '1) begin
      gap++;
      @(negedge clk);
    end
    check("R3 commit+delay gap", gap, 6);
    check("R2 single row low", $countones(~rowDrive_n), 1);

    // table of key patterns: R1 R4 R5
    for (int v = 0; v < 6; v++) begin
      setKeys(VECS[v].keys);
      settle();
      regRead(1, rd);
      check($sformatf("R4 count vec%0d", v), rd[7:4], VECS[v].cnt);
      regRead(2, rd);
      check($sformatf("R1 word0 vec%0d", v), rd, VECS[v].word0);
      regRead(2, rd);
      check($sformatf("R5 word0 reread vec%0d", v), rd, VECS[v].word0);
      regRead(3, rd);
      check($sformatf("R1 word1 vec%0d", v), rd, 0);
      regRead(1, rd);
      check($sformatf("R5 count after pop vec%0d", v), rd[7:4], 0);
    end

    // R4 overflow: ten keys, first eight kept
    keys = '0;
    keys[0] = 8'hFF;
    keys[1] = 8'h03;
    settle();
    regRead(1, rd);
    check("R4 overflow count", rd[7:4], 8);
    regRead(2, rd);
    check("R1 overflow word0", rd, 32'h83828180);
    regRead(3, rd);
    check("R1 overflow word1", rd, 32'h87868584);
    regRead(2, rd);
    check("R5 word0 cleared after pop", rd, 0);

    // R6 debounce with D=4, flickering key rejected
    keys = '0;
    keys[5][4] = 1'b1;
    flickOn = 1'b1;
    regWrite(0, ctrlWord(0, 0, 4, 1));
    measureRow("R3 row dwell D=4", 20);
    settle();
    regRead(1, rd);
    check("R6 flicker rejected count", rd[7:4], 1);
    regRead(2, rd);
    check("R6 steady key kept", rd, 32'h000000AC);
    flickOn = 1'b0;

    // R7 threshold flag, R9 write-one-to-clear, R11 irq gating
    regWrite(0, ctrlWord(0, 1, 0, 2));
    keys = '0;
    keys[0][0] = 1'b1;
    settle();
    regWrite(1, 32'h5);
    settle();
    regRead(1, rd);
    check("R7 below threshold", rd[2], 0);
    check("R11 irq low below threshold", irq, 0);
    keys[0][1] = 1'b1;
    settle();
    regRead(1, rd);
    check("R7 at threshold", rd[2], 1);
    check("R11 irq on threshold", irq, 1);
    syncToScan();
    regWrite(1, 32'h4);
    regRead(1, rd);
    check("R9 bit2 cleared", rd[2], 0);
    check("R9 bit0 untouched", rd[0], 1);
    check("R11 kp flag without enable", irq, 0);

    // R8 wake mask
    regWrite(0, ctrlWord(1, 0, 0, 0));
    regWrite(16 + 2, 32'hFF);
    keys = '0;
    keys[2][1] = 1'b1;
    settle();
    syncToScan();
    regWrite(1, 32'h5);
    settle();
    regRead(1, rd);
    check("R8 masked row no flag", rd[0], 0);
    check("R11 masked irq low", irq, 0);
    regRead(18, rd2);
    check("R8 mask readback", rd2, 32'hFF);
    regWrite(16 + 2, 32'h7F);
    settle();
    regRead(1, rd);
    check("R8 partial mask flags", rd[0], 1);
    check("R11 irq on keypress", irq, 1);

    // R10 disable holds everything in reset
    regWrite(0, 32'h0);
    regRead(1, rd);
    check("R10 status cleared", rd, 0);
    check("R10 irq cleared", irq, 0);
    check("R2 rows idle when disabled", rowDrive_n, 32'h0000FFFF);
    regRead(2, rd);
    check("R10 entries cleared", rd, 0);
    repeat (300) @(negedge clk);
    check("R2 rows stay idle", rowDrive_n, 32'h0000FFFF);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule